// File: doc/BRIEF.md
# Double-Word Instruction Decoder

This block sits in the decode stage of a small processor whose instructions are normally one 16-bit program word long, but a few of them take two words. Each fetched word arrives with a valid strobe and a skip request. The skip request is raised by an earlier conditional instruction and means that the word presented now must not take effect. The block issues one decoded instruction for every executed instruction. A single-word instruction passes straight through. A double-word instruction is held back after its first word and released as one combined record when its continuation word arrives. That record carries both operand fields and a flag saying that an extra word was consumed.

Continuation words always have an all-ones top nibble. If a skip causes the first word of a pair to be dropped, the continuation word that follows arrives with nothing pending and decodes as a no-operation. Skipping over a double-word instruction is therefore safe without knowing instruction lengths ahead of time.

The control is a two-state machine. `ST_FIRST` expects the start of an instruction. `ST_SECOND` holds the captured first half of a pair. The transitions are:
- `capture`: `ST_FIRST` to `ST_SECOND`, on an executed first word.
- `absorb`: `ST_SECOND` to `ST_FIRST`, on an executed continuation.
- `discard`: `ST_SECOND` to `ST_FIRST`, on a skipped word.
- `hold`: either state back to itself, when no word is valid or when a single or stand-alone word is decoded in `ST_FIRST`.

Top module: `dword_fetch_decoder`

## Requirements
- R1: Reset (active-low `rst_n`) clears `out_valid`, `out_extra`, `out_class`, `out_a` and `out_b` to 0. It also clears any half-captured pair, so a continuation word fed right after reset decodes as a no-operation.
- R2: An executed word that is neither a double-word first word nor a continuation is issued as class SINGLE (1). `out_a` carries word bits [11:0], `out_b` is 0 and `out_extra` is 0.
- R3: A word whose top nibble is 1100 is the first word of a file-to-file move. It produces no output, and its bits [11:0] (source address) are held. The next valid, unskipped word is absorbed as its continuation and issues class MOVE (2), with `out_a` set to the source, `out_b` set to that word's bits [11:0] and `out_extra` set to 1.
- R4: First words with top byte 0xEC (call), 0xEF (absolute jump) and 0xEE (load pointer) behave like R3 with classes CALL (3), JUMP (4) and LDPTR (5). For these, `out_a` is the first word's bits [7:0] zero-extended to 12 bits.
- R5: A word with top nibble 1111 reaching the decoder with no pair pending issues class NOP (0), with `out_a`, `out_b` and `out_extra` all 0.
- R6: A valid word presented with `in_skip` high while no pair is pending issues NOP, whatever the word is. A skipped first word captures nothing.
- R7: A skip request on the word following a captured first word discards the held pair and issues NOP. The next word is decoded as a fresh first word.
- R8: `out_extra` is 1 only together with a combined double-word class, for exactly one cycle per absorbed continuation.
- R9: A cycle with `in_valid` low changes no state and gives `out_valid` 0 with all output fields 0 in the following cycle.
- R10: Every issued record appears on the outputs in the cycle after the clock edge that accepted its last word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A fetched word is present |
| in_skip | input | 1 | The present word was skipped by a prior conditional |
| in_word | input | 16 | Fetched program word |
| out_valid | output | 1 | A decoded instruction is issued |
| out_class | output | 3 | Class: 0 NOP, 1 SINGLE, 2 MOVE, 3 CALL, 4 JUMP, 5 LDPTR |
| out_a | output | 12 | First-word operand field |
| out_b | output | 12 | Continuation operand field |
| out_extra | output | 1 | An extra program word was consumed |

## Verification
The bench targets a skip that lands on the first word of a pair, followed by its stand-alone continuation. A decoder that still captured the skipped word would swallow the next real instruction as an operand. It also skips the continuation while a pair is pending. A design that kept the held state would merge a stale source address into the following instruction. A reset with a pair half-captured is applied before a lone continuation word; leftover state would show up as a spurious MOVE. Gaps in the valid strobe are placed between the two halves of a pair, and a design that counted idle cycles as words would lose the operand.

// File: rtl/dw_pkg.sv
package dw_pkg;
    localparam int WORD_W  = 16;
    localparam int TAG_W   = 4;
    localparam int FIELD_W = WORD_W - TAG_W;
    localparam int LIT_W   = 8;
    localparam int CLS_W   = 3;

    localparam logic [TAG_W-1:0] TAG_MOVE = 4'b1100;
    localparam logic [TAG_W-1:0] TAG_CONT = 4'b1111;
    localparam logic [7:0]       TOP_CALL = 8'hEC;
    localparam logic [7:0]       TOP_JUMP = 8'hEF;
    localparam logic [7:0]       TOP_LDP  = 8'hEE;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP    = 3'd0,
        CLS_SINGLE = 3'd1,
        CLS_MOVE   = 3'd2,
        CLS_CALL   = 3'd3,
        CLS_JUMP   = 3'd4,
        CLS_LDPTR  = 3'd5
    } dw_cls_e;

    typedef enum logic {
        ST_FIRST  = 1'b0,
        ST_SECOND = 1'b1
    } dw_state_e;
endpackage

// File: rtl/dw_classify.sv
module dw_classify
    import dw_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int TW = TAG_W,
    localparam int FW = W - TW
) (
    input  logic [W-1:0]  word,
    output logic          is_first,
    output logic          is_cont,
    output dw_cls_e       first_cls,
    output logic [FW-1:0] first_field
);
    logic [TW-1:0] tag;
    logic [7:0]    top;

    always_comb begin
        tag         = word[W-1 -: TW];
        top         = word[W-1 -: 8];
        is_cont     = (tag == TAG_CONT);
        is_first    = 1'b1;
        first_cls   = CLS_SINGLE;
        first_field = word[FW-1:0];
        if (tag == TAG_MOVE) begin
            first_cls = CLS_MOVE;
        end else if (top == TOP_CALL) begin
            first_cls   = CLS_CALL;
            first_field = {{(FW-LIT_W){1'b0}}, word[LIT_W-1:0]};
        end else if (top == TOP_JUMP) begin
            first_cls   = CLS_JUMP;
            first_field = {{(FW-LIT_W){1'b0}}, word[LIT_W-1:0]};
        end else if (top == TOP_LDP) begin
            first_cls   = CLS_LDPTR;
            first_field = {{(FW-LIT_W){1'b0}}, word[LIT_W-1:0]};
        end else begin
            is_first = 1'b0;
        end
    end
endmodule

// File: rtl/dw_fsm.sv
module dw_fsm
    import dw_pkg::*;
#(
    parameter int FW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_skip,
    input  logic [FW-1:0] in_field,
    input  logic          is_first,
    input  logic          is_cont,
    input  dw_cls_e       first_cls,
    input  logic [FW-1:0] first_field,
    output logic          out_valid,
    output dw_cls_e       out_class,
    output logic [FW-1:0] out_a,
    output logic [FW-1:0] out_b,
    output logic          out_extra
);
    dw_state_e     st, st_nxt;
    dw_cls_e       held_cls, held_cls_nxt;
    logic [FW-1:0] held_a, held_a_nxt;

    logic          v_d, x_d;
    dw_cls_e       c_d;
    logic [FW-1:0] a_d, b_d;

    // next-state and hold logic
    always_comb begin
        st_nxt       = st;
        held_cls_nxt = held_cls;
        held_a_nxt   = held_a;
        unique case (st)
            ST_FIRST: begin
                if (in_valid && !in_skip && is_first) begin
                    st_nxt       = ST_SECOND;        // capture
                    held_cls_nxt = first_cls;
                    held_a_nxt   = first_field;
                end
            end
            ST_SECOND: begin
                if (in_valid) begin
                    st_nxt       = ST_FIRST;         // absorb or discard
                    held_cls_nxt = CLS_NOP;
                    held_a_nxt   = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_FIRST;
            held_cls <= CLS_NOP;
            held_a   <= '0;
        end else begin
            st       <= st_nxt;
            held_cls <= held_cls_nxt;
            held_a   <= held_a_nxt;
        end
    end

    // output decode
    always_comb begin
        v_d = 1'b0;
        x_d = 1'b0;
        c_d = CLS_NOP;
        a_d = '0;
        b_d = '0;
        if (in_valid) begin
            unique case (st)
                ST_FIRST: begin
                    if (in_skip || is_cont) begin
                        v_d = 1'b1;
                    end else if (!is_first) begin
                        v_d = 1'b1;
                        c_d = CLS_SINGLE;
                        a_d = in_field;
                    end
                end
                ST_SECOND: begin
                    v_d = 1'b1;
                    if (!in_skip) begin
                        c_d = held_cls;
                        a_d = held_a;
                        b_d = in_field;
                        x_d = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_class <= CLS_NOP;
            out_a     <= '0;
            out_b     <= '0;
            out_extra <= 1'b0;
        end else begin
            out_valid <= v_d;
            out_class <= c_d;
            out_a     <= a_d;
            out_b     <= b_d;
            out_extra <= x_d;
        end
    end

    p_first_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRST && in_valid && !in_skip && is_first) |=> (!out_valid && st == ST_SECOND));

    p_pending_absorbs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SECOND && in_valid && !in_skip) |=> (out_valid && out_extra && st == ST_FIRST));

    p_cont_alone_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRST && in_valid && is_cont) |=> (out_valid && out_class == CLS_NOP && !out_extra));

    p_skip_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_skip) |=> (out_valid && out_class == CLS_NOP && !out_extra));

    p_skip_discards_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SECOND && in_valid && in_skip) |=> (st == ST_FIRST));

    p_extra_double_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_extra |-> (out_valid && (out_class == CLS_MOVE || out_class == CLS_CALL ||
                                     out_class == CLS_JUMP || out_class == CLS_LDPTR)));

    p_gap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(st)));

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
endmodule

// File: rtl/dword_fetch_decoder.sv
module dword_fetch_decoder
    import dw_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int TW = TAG_W,
    localparam int FW = W - TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_skip,
    input  logic [W-1:0]  in_word,
    output logic          out_valid,
    output logic [2:0]    out_class,
    output logic [FW-1:0] out_a,
    output logic [FW-1:0] out_b,
    output logic          out_extra
);
    logic          is_first, is_cont;
    dw_cls_e       first_cls, cls_q;
    logic [FW-1:0] first_field;

    dw_classify #(.W(W), .TW(TW)) u_cls (
        .word        (in_word),
        .is_first    (is_first),
        .is_cont     (is_cont),
        .first_cls   (first_cls),
        .first_field (first_field)
    );

    dw_fsm #(.FW(FW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_skip     (in_skip),
        .in_field    (in_word[FW-1:0]),
        .is_first    (is_first),
        .is_cont     (is_cont),
        .first_cls   (first_cls),
        .first_field (first_field),
        .out_valid   (out_valid),
        .out_class   (cls_q),
        .out_a       (out_a),
        .out_b       (out_b),
        .out_extra   (out_extra)
    );

    assign out_class = cls_q;
endmodule

// File: tb/sim_dword_fetch_decoder.sv
`timescale 1ns/1ps
module sim_dword_fetch_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_skip = 1'b0;
    logic [15:0] in_word = 16'h0000;
    logic        out_valid, out_extra;
    logic [2:0]  out_class;
    logic [11:0] out_a, out_b;

    int checks = 0;
    int errors = 0;

    // model state
    bit          m_pend = 0;
    logic [2:0]  m_cls = 0;
    logic [11:0] m_a = 0;
    logic [28:0] exp_vec;

    always #2.5 clk = ~clk;

    dword_fetch_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_skip(in_skip),
        .in_word(in_word), .out_valid(out_valid), .out_class(out_class),
        .out_a(out_a), .out_b(out_b), .out_extra(out_extra)
    );

    // 0: not a first word, else class 2..5
    function automatic logic [2:0] first_class(input logic [15:0] w);
        if (w[15:12] == 4'b1100) return 3'd2;
        if (w[15:8] == 8'hEC)    return 3'd3;
        if (w[15:8] == 8'hEF)    return 3'd4;
        if (w[15:8] == 8'hEE)    return 3'd5;
        return 3'd0;
    endfunction

    function automatic string tag_of(input logic [28:0] e, input bit skp, input bit pend);
        if (!e[28])              return "R9";
        if (e[27])               return (e[26:24] == 3'd2) ? "R3" : "R4";
        if (e[26:24] == 3'd1)    return "R2";
        if (skp && pend)         return "R7";
        if (skp)                 return "R6";
        return "R5";
    endfunction

    task automatic compare(input string tag);
        logic [28:0] act;
        act = {out_valid, out_extra, out_class, out_a, out_b};
        checks++;
        if (act !== exp_vec) begin
            errors++;
            $display("FAIL %s: actual v=%b x=%b c=%0d a=%h b=%h expected v=%b x=%b c=%0d a=%h b=%h",
                     tag, act[28], act[27], act[26:24], act[23:12], act[11:0],
                     exp_vec[28], exp_vec[27], exp_vec[26:24], exp_vec[23:12], exp_vec[11:0]);
        end
    endtask

    // drive one word at negedge, model it, check after the next posedge (R10)
    task automatic step(input bit v, input bit s, input logic [15:0] w);
        logic [2:0] fc;
        bit was_pend;
        string tg;
        in_valid = v; in_skip = s; in_word = w;
        was_pend = m_pend;
        fc = first_class(w);
        exp_vec = '0;
        if (v) begin
            if (m_pend) begin
                exp_vec[28] = 1'b1;
                if (!s) exp_vec = {1'b1, 1'b1, m_cls, m_a, w[11:0]};
                m_pend = 0;
            end else if (s || w[15:12] == 4'b1111) begin
                exp_vec[28] = 1'b1;
            end else if (fc != 0) begin
                m_pend = 1;
                m_cls = fc;
                m_a = (fc == 3'd2) ? w[11:0] : {4'h0, w[7:0]};
            end else begin
                exp_vec = {1'b1, 1'b0, 3'd1, w[11:0], 12'h000};
            end
        end
        tg = tag_of(exp_vec, s, was_pend);
        @(negedge clk);
        compare(tg);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 0; in_skip = 0;
        @(negedge clk); @(negedge clk);
        exp_vec = '0;
        compare("R1");
        m_pend = 0;
        rst_n = 1'b1;
    endtask

    function automatic logic [15:0] rand_word(input int kind);
        logic [15:0] w;
        case (kind)
            0: w = {4'b1100, 12'($urandom)};
            1: w = {8'hEC, 8'($urandom)};
            2: w = {8'hEF, 8'($urandom)};
            3: w = {8'hEE, 8'($urandom)};
            4: w = {4'b1111, 12'($urandom)};
            default: begin
                w = 16'($urandom);
                while (first_class(w) != 0 || w[15:12] == 4'b1111) w = 16'($urandom);
            end
        endcase
        return w;
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        // R1: pending pair cleared by reset
        step(1, 0, 16'hC123);
        do_reset();
        step(1, 0, 16'hF456);                 // R1 then lone continuation -> NOP
        // R3: move pair executed
        step(1, 0, 16'hC123);
        step(1, 0, 16'hF456);
        // R6/R5: first word skipped, continuation alone -> NOP
        step(1, 1, 16'hC123);
        step(1, 0, 16'hF456);
        // R2: single word
        step(1, 0, 16'h2400);
        // R4: call with a gap between halves (R9)
        step(1, 0, 16'hEC5A);
        step(0, 0, 16'hFFFF);
        step(0, 1, 16'h1234);
        step(1, 0, 16'hF9AB);
        // R7: skip discards pending pair; next word is a fresh first word
        step(1, 0, 16'hEF11);
        step(1, 1, 16'hF222);
        step(1, 0, 16'hEE07);
        step(1, 0, 16'hF333);
        // R8: back-to-back pairs
        step(1, 0, 16'hCFFF);
        step(1, 0, 16'hF000);
        step(1, 0, 16'hEF80);
        step(1, 0, 16'hFFFF);
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int kind;
            bit v, s;
            kind = int'($urandom % 9);
            v = ($urandom % 4) != 0;
            s = ($urandom % 6) == 0;
            step(v, s, rand_word(kind));
        end
        step(0, 0, 16'h0000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule